// File: doc/BRIEF.md
# Zero-Suppressed Super-Column Frame Packer

This block turns the hit pattern of one super-column (eight groups of 16x16 pixels, each pixel carrying a 4-bit charge code) into a compact stream of 16-bit words. Readout is event-driven. A pulse on the trigger input, taken from the matrix-wide fast-OR, starts a frame when the packer is idle. The frame clock runs at 200 MHz.

Compression works on two levels. A group with no hits costs a single cleared bit in the header mask and nothing else. A group with hits sends its occupancy as sixteen bitmap words, one per pixel row. Its charge codes follow, but only for the pixels whose bitmap bit is set, packed four to a word. A trigger that finds no hits in the whole super-column produces no output at all. A trigger that arrives while a frame is still being sent is counted and then discarded.

The hit bitmap and code inputs must be held stable from the accepted trigger until the word marked last has been accepted. The output uses a valid/ready handshake, so a downstream stall pauses the packer and loses nothing.

Top module: `sc_frame_packer`

## Requirements
- R1: After reset, `out_valid_o` is 0, `drop_cnt_o` is 0, and the trigger tag of the first frame is 0.
- R2: A trigger accepted while idle with at least one hit makes the first word of the frame a header. Its bits [15:12] hold the trigger tag, bits [11:9] hold `sc_id_i` sampled at the trigger, bit 1+g of [8:1] is set exactly when group g has any hit, and bit 0 is 0.
- R3: A trigger accepted while idle with no hit in any group produces no output word, but it still consumes a trigger tag.
- R4: After the header, each occupied group sends sixteen bitmap words in ascending group order. Word r of a group carries bit c equal to the hit bit of pixel r*16+c.
- R5: After a group's bitmap words come the codes of its hit pixels, in ascending pixel index. Each word holds four codes, with the earliest code in bits [3:0]. The group's final code word has its unused nibbles set to zero.
- R6: `out_last_o` is 1 on the final word of each frame and 0 on every other word, and it is only ever 1 together with `out_valid_o`.
- R7: A trigger present on any clock edge at which a frame is in progress (from the accepting edge, up to and including the edge that accepts the last word) is not queued. It increments `drop_cnt_o`, which saturates at its all-ones value, and it changes neither the frame nor the tag sequence.
- R8: While `out_valid_o` is 1 and `out_ready_i` is 0, `out_valid_o`, `out_data_o` and `out_last_o` hold their values. No word is skipped or repeated.
- R9: The trigger tag increases by one for each accepted trigger and wraps modulo 16.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| trig_i | input | 1 | Fast-OR readout trigger |
| sc_id_i | input | 3 | Super-column identifier placed in the header |
| hit_map_i | input | 2048 | Hit bits; group g, pixel i at bit g*256+i |
| code_i | input | 8192 | Charge codes; group g, pixel i at bits (g*256+i)*4 +: 4 |
| out_ready_i | input | 1 | Downstream accepts a word |
| out_valid_o | output | 1 | Output word present |
| out_data_o | output | 16 | Output word |
| out_last_o | output | 1 | Final word of the frame |
| drop_cnt_o | output | 8 | Saturating count of triggers discarded while busy |

## Verification
Most internal faults show up in the content of the very next word that is accepted. A wrong group pointer, row counter or pixel pointer sends a bitmap row or a code nibble from the wrong place. A wrong fill count shifts the code packing. A wrong state makes a word appear when no frame is expected. A tag or drop counter that is off by one shows up in the next header, or in `drop_cnt_o` one edge after the offending trigger. A stuck handshake shows up as a changed word under stall, or as a word still outstanding when the stimulus ends.

// File: rtl/sc_fp_pkg.sv
package sc_fp_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_HDR  = 2'd1,
      ST_BMP  = 2'd2,
      ST_CODE = 2'd3
   } fp_state_e;
endpackage

// File: rtl/sc_fp_first.sv
// Lowest set bit of vec_i at or above from_i.
module sc_fp_first #(
   parameter int W  = 256,
   parameter int FW = $clog2(W) + 1
) (
   input  logic [W-1:0]  vec_i,
   input  logic [FW-1:0] from_i,
   output logic          found_o,
   output logic [FW-1:0] idx_o
);
   always_comb begin
      found_o = 1'b0;
      idx_o   = '0;
      for (int i = W - 1; i >= 0; i--) begin
         if (vec_i[i] && (FW'(i) >= from_i)) begin
            found_o = 1'b1;
            idx_o   = FW'(i);
         end
      end
   end
endmodule

// File: rtl/sc_fp_occ.sv
// One occupancy bit per pixel group.
module sc_fp_occ #(
   parameter int N_GROUPS = 8,
   parameter int PIX      = 256
) (
   input  logic [N_GROUPS*PIX-1:0] map_i,
   output logic [N_GROUPS-1:0]     mask_o
);
   for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
      assign mask_o[g] = |map_i[g*PIX +: PIX];
   end
endmodule

// File: rtl/sc_frame_packer.sv
module sc_frame_packer
   import sc_fp_pkg::*;
#(
   parameter int N_GROUPS = 8,
   parameter int ROWS     = 16,
   parameter int COLS     = 16,
   parameter int CODE_W   = 4,
   parameter int WORD_W   = 16,
   parameter int TAG_W    = 4,
   parameter int SCID_W   = 3,
   parameter int DROP_W   = 8
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 trig_i,
   input  logic [SCID_W-1:0]                    sc_id_i,
   input  logic [N_GROUPS*ROWS*COLS-1:0]        hit_map_i,
   input  logic [N_GROUPS*ROWS*COLS*CODE_W-1:0] code_i,
   input  logic                                 out_ready_i,
   output logic                                 out_valid_o,
   output logic [WORD_W-1:0]                    out_data_o,
   output logic                                 out_last_o,
   output logic [DROP_W-1:0]                    drop_cnt_o
);
   localparam int PIX     = ROWS * COLS;
   localparam int GW      = $clog2(N_GROUPS);
   localparam int GFW     = GW + 1;
   localparam int RW      = $clog2(ROWS);
   localparam int PW      = $clog2(PIX) + 1;
   localparam int CPW     = WORD_W / CODE_W;
   localparam int KW      = $clog2(CPW + 1);
   localparam int HDR_W   = TAG_W + SCID_W + N_GROUPS;
   localparam int HDR_PAD = WORD_W - HDR_W;

   // elaboration-time parameter checks
   if (COLS != WORD_W) begin : g_bad_cols
      $error("one bitmap row must fill one output word");
   end
   if ((WORD_W % CODE_W) != 0) begin : g_bad_code
      $error("codes must tile the output word");
   end
   if (HDR_W > WORD_W) begin : g_bad_hdr
      $error("header fields exceed the output word");
   end

   fp_state_e            state_q;
   logic [TAG_W-1:0]     tag_q, hdr_tag_q;
   logic [SCID_W-1:0]    scid_q;
   logic [N_GROUPS-1:0]  mask_q, mask_in;
   logic [GW-1:0]        g_q;
   logic [RW-1:0]        r_q;
   logic [PW-1:0]        p_q;
   logic [KW-1:0]        k_q;
   logic [WORD_W-1:0]    acc_q;
   logic [DROP_W-1:0]    drop_q;

   logic                 grp_found, pix_found, emit;
   logic [GFW-1:0]       grp_from, grp_idx;
   logic [PW-1:0]        pix_idx;
   logic [PIX-1:0]       grp_map;
   logic [CODE_W-1:0]    cur_code;
   logic [WORD_W-1:0]    hdr_word;

   sc_fp_occ #(.N_GROUPS(N_GROUPS), .PIX(PIX)) u_occ (
      .map_i (hit_map_i),
      .mask_o(mask_in)
   );

   assign grp_from = (state_q == ST_HDR) ? '0 : (GFW'(g_q) + 1'b1);

   sc_fp_first #(.W(N_GROUPS), .FW(GFW)) u_grp (
      .vec_i  (mask_q),
      .from_i (grp_from),
      .found_o(grp_found),
      .idx_o  (grp_idx)
   );

   assign grp_map  = hit_map_i[int'(g_q)*PIX +: PIX];

   sc_fp_first #(.W(PIX), .FW(PW)) u_pix (
      .vec_i  (grp_map),
      .from_i (p_q),
      .found_o(pix_found),
      .idx_o  (pix_idx)
   );

   assign cur_code = code_i[(int'(g_q)*PIX + int'(pix_idx))*CODE_W +: CODE_W];
   assign emit     = (k_q == KW'(CPW)) || (!pix_found && (k_q != '0));
   assign hdr_word = WORD_W'({hdr_tag_q, scid_q, mask_q}) << HDR_PAD;

   always_comb begin
      out_valid_o = 1'b0;
      out_data_o  = '0;
      out_last_o  = 1'b0;
      case (state_q)
         ST_HDR: begin
            out_valid_o = 1'b1;
            out_data_o  = hdr_word;
         end
         ST_BMP: begin
            out_valid_o = 1'b1;
            out_data_o  = grp_map[int'(r_q)*COLS +: COLS];
         end
         ST_CODE: begin
            out_valid_o = emit;
            out_data_o  = acc_q;
            out_last_o  = emit && !pix_found && !grp_found;
         end
         default: ;
      endcase
   end

   assign drop_cnt_o = drop_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         tag_q     <= '0;
         hdr_tag_q <= '0;
         scid_q    <= '0;
         mask_q    <= '0;
         g_q       <= '0;
         r_q       <= '0;
         p_q       <= '0;
         k_q       <= '0;
         acc_q     <= '0;
         drop_q    <= '0;
      end else begin
         if (trig_i && (state_q != ST_IDLE) && (drop_q != '1))
            drop_q <= drop_q + 1'b1;
         case (state_q)
            ST_IDLE: if (trig_i) begin
               tag_q <= tag_q + 1'b1;
               if (|mask_in) begin
                  hdr_tag_q <= tag_q;
                  scid_q    <= sc_id_i;
                  mask_q    <= mask_in;
                  state_q   <= ST_HDR;
               end
            end
            ST_HDR: if (out_ready_i) begin
               g_q     <= grp_idx[GW-1:0];
               r_q     <= '0;
               state_q <= ST_BMP;
            end
            ST_BMP: if (out_ready_i) begin
               if (r_q == RW'(ROWS - 1)) begin
                  p_q     <= '0;
                  k_q     <= '0;
                  acc_q   <= '0;
                  state_q <= ST_CODE;
               end else begin
                  r_q <= r_q + 1'b1;
               end
            end
            ST_CODE: begin
               if (!emit) begin
                  acc_q[int'(k_q)*CODE_W +: CODE_W] <= cur_code;
                  k_q <= k_q + 1'b1;
                  p_q <= pix_idx + 1'b1;
               end else if (out_ready_i) begin
                  acc_q <= '0;
                  k_q   <= '0;
                  if (!pix_found) begin
                     if (grp_found) begin
                        g_q     <= grp_idx[GW-1:0];
                        r_q     <= '0;
                        state_q <= ST_BMP;
                     end else begin
                        state_q <= ST_IDLE;
                     end
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R6
   last_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_last_o |-> out_valid_o);

   // R8
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid_o && !out_ready_i) |=>
         (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));

   // R3
   hdr_mask_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_HDR) |-> (mask_q != '0));

   // R7
   drop_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && (state_q != ST_IDLE) && (drop_q != '1)) |=>
         (drop_q == $past(drop_q) + 1'b1));

   // R9
   tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (trig_i && (state_q == ST_IDLE)) |=> (tag_q == $past(tag_q) + 1'b1));

   // R5
   fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      k_q <= KW'(CPW));
endmodule

// File: tb/sc_frame_packer_test.sv
module sc_frame_packer_test;
   localparam int NG  = 8;
   localparam int PIX = 256;

   logic                  clk = 1'b0;
   logic                  rst_n;
   logic                  trig;
   logic [2:0]            scid;
   logic [NG*PIX-1:0]     hmap;
   logic [NG*PIX*4-1:0]   codes;
   logic                  ready;
   logic                  valid, last;
   logic [15:0]           data;
   logic [7:0]            drop;

   sc_frame_packer uut (
      .clk(clk), .rst_n(rst_n), .trig_i(trig), .sc_id_i(scid),
      .hit_map_i(hmap), .code_i(codes), .out_ready_i(ready),
      .out_valid_o(valid), .out_data_o(data), .out_last_o(last),
      .drop_cnt_o(drop)
   );

   always #4 clk = ~clk;

   int tests = 0, fails = 0;
   int ready_mode = 0, rcnt = 0;
   bit timed_out = 0, mon_on = 0, first_tick = 1;

   logic [15:0] q_word[$];
   bit          q_last[$];
   string       q_req[$];
   logic [3:0]  m_tag = 0;
   int          m_drop = 0;
   bit          m_busy = 0;
   bit          prev_stall = 0;
   logic [15:0] prev_data;
   bit          prev_last;

   task automatic chk(bit ok, string req, int act, int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic push(logic [15:0] w, string req);
      q_word.push_back(w);
      q_last.push_back(1'b0);
      q_req.push_back(req);
   endtask

   // behavioural frame builder from the requirements
   task automatic build_frame();
      logic [7:0]  mask;
      logic [15:0] w;
      int n;
      for (int g = 0; g < NG; g++) mask[g] = |hmap[g*PIX +: PIX];
      if (mask != 0) begin
         push({m_tag, scid, mask, 1'b0}, "R2");
         for (int g = 0; g < NG; g++) begin
            if (mask[g]) begin
               for (int r = 0; r < 16; r++) push(hmap[g*PIX + r*16 +: 16], "R4");
               w = 0; n = 0;
               for (int i = 0; i < PIX; i++) begin
                  if (hmap[g*PIX + i]) begin
                     w[n*4 +: 4] = codes[(g*PIX + i)*4 +: 4];
                     n++;
                     if (n == 4) begin push(w, "R5"); w = 0; n = 0; end
                  end
               end
               if (n > 0) push(w, "R5");
            end
         end
         q_last[q_last.size()-1] = 1'b1;
         m_busy = 1;
      end
      m_tag = m_tag + 1'b1;
   endtask

   always @(negedge clk) begin
      rcnt++;
      case (ready_mode)
         0: ready = 1'b1;
         1: ready = (rcnt % 3) != 0;
         default: ready = (rcnt % 7) == 0;
      endcase
   end

   // cycle-by-cycle reference comparison, just before each rising edge
   always @(negedge clk) begin
      #1;
      if (mon_on) begin
         if (first_tick) begin
            chk(valid == 1'b0, "R1 valid after reset", int'(valid), 0);
            chk(drop == 8'd0, "R1 drop after reset", int'(drop), 0);
            first_tick = 0;
         end
         chk(int'(drop) == m_drop, "R7 drop count", int'(drop), m_drop);
         if (prev_stall) begin
            chk(valid == 1'b1, "R8 valid held", int'(valid), 1);
            chk(data == prev_data, "R8 data held", int'(data), int'(prev_data));
            chk(last == prev_last, "R8 last held", int'(last), int'(prev_last));
         end
         if (trig) begin
            if (m_busy) begin
               if (m_drop < 255) m_drop++;
            end else build_frame();
         end
         if (valid) begin
            if (q_word.size() == 0) begin
               chk(1'b0, "R3 word without frame", int'(data), 0);
            end else if (ready) begin
               chk(data == q_word[0], q_req[0], int'(data), int'(q_word[0]));
               chk(last == q_last[0], "R6 last flag", int'(last), int'(q_last[0]));
               if (q_last[0]) m_busy = 0;
               void'(q_word.pop_front());
               void'(q_last.pop_front());
               void'(q_req.pop_front());
            end
         end else if (last) begin
            chk(1'b0, "R6 last without valid", 1, 0);
         end
         prev_stall = valid && !ready;
         prev_data  = data;
         prev_last  = last;
      end
   end

   task automatic fire();
      @(negedge clk); trig = 1'b1;
      @(negedge clk); trig = 1'b0;
   endtask

   task automatic wait_idle();
      do @(negedge clk); while (m_busy);
      repeat (3) @(negedge clk);
   endtask

   task automatic set_hit(int g, int i, logic [3:0] c);
      hmap[g*PIX + i] = 1'b1;
      codes[(g*PIX + i)*4 +: 4] = c;
   endtask

   task automatic clear_all();
      hmap = '0;
      codes = '0;
   endtask

   task automatic run_all();
      rst_n = 1'b0; trig = 1'b0; scid = 3'd0; clear_all();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      mon_on = 1;
      repeat (2) @(negedge clk);
      // R2 R4 R5: one group, partial code word (tag 0 checks R1)
      scid = 3'd5;
      set_hit(3, 1, 4'h9); set_hit(3, 17, 4'h3); set_hit(3, 200, 4'hF);
      fire(); wait_idle();
      // R3: empty super-column
      clear_all(); scid = 3'd2;
      fire(); repeat (10) @(negedge clk);
      // R4 R5 R7 R8: three groups, backpressure, triggers while busy
      ready_mode = 1; scid = 3'd6;
      for (int i = 0; i < 4; i++) set_hit(0, i, 4'(i + 1));
      set_hit(5, 10, 4'h1); set_hit(5, 31, 4'h2); set_hit(5, 64, 4'h4);
      set_hit(5, 128, 4'h8); set_hit(5, 129, 4'hA);
      for (int i = 0; i < 9; i++) set_hit(7, 255 - i*13, 4'(15 - i));
      fire(); repeat (5) @(negedge clk); fire(); fire();
      wait_idle();
      // R5 R7: full group, trigger held high long enough to saturate
      ready_mode = 0; clear_all(); scid = 3'd1;
      for (int i = 0; i < PIX; i++) set_hit(6, i, 4'(i % 16));
      @(negedge clk); trig = 1'b1;
      repeat (300) @(negedge clk);
      trig = 1'b0;
      wait_idle();
      // R8: long stalls
      ready_mode = 2; clear_all(); scid = 3'd7;
      set_hit(1, 0, 4'hC); set_hit(2, 255, 4'h5); set_hit(2, 100, 4'h6);
      fire(); wait_idle();
      // R9: tag wrap via empty triggers, then a frame
      ready_mode = 0; clear_all();
      for (int i = 0; i < 16; i++) fire();
      set_hit(4, 77, 4'h7); scid = 3'd3;
      fire(); wait_idle();
      chk(q_word.size() == 0, "R8 no word lost", q_word.size(), 0);
   endtask

   initial begin
      fork
         run_all();
         begin repeat (150000) @(posedge clk); timed_out = 1; end
      join_any
      if (timed_out) begin
         tests++; fails++;
         $display("FAIL watchdog (all requirements): actual timeout expected completion");
      end
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule